// File: doc/BRIEF.md
# Remote Terminal Error Status Register

This block holds the condition flags that a serial command/response remote terminal reports to its host. An upstream word decoder hands it one-cycle pulses: a valid command (with the bus it arrived on, its terminal address, its transmit/receive bit, a mode-command marker and the shared 5-bit word-count/mode-code field) and an end-of-message pulse with the number of valid data words actually received. From these the block keeps three sticky message flags: too few words, too many words, and a broadcast that would need the terminal to transmit.

Besides those, the status word carries per-bus shutdown and a terminal-flag-inhibit bit, which follow their level inputs. It also carries per-bus transmitter-timeout bits, which are latched until the host strobes a clear. The host loads an 8-bit address word holding the terminal's own address, an odd-parity bit and two per-bus broadcast enables. The block checks that word's parity and uses it to decide which commands are meant for this terminal. The three mode commands that read back status, the last command or the built-in-test word leave the message flags untouched, so the host can fetch the error state without wiping it.

Top module: `rt_err_status`

## Requirements
- R1: After reset `stat_word` message and timeout bits are 0, `aw_q` is 8'h20 (address 0, parity bit 1, both broadcast enables 0) and `addr_err` is 0.
- R2: A cycle with `aw_we` high loads `aw_wdata` into `aw_q`, visible after the next clock edge; bits [4:0] are the own address, bit 5 the parity bit, bit 6 the bus 0 broadcast enable, bit 7 the bus 1 broadcast enable.
- R3: `addr_err` is 1 exactly when `aw_q[5:0]` holds an even number of ones.
- R4: A command is accepted when `cmd_addr` equals the own address and `addr_err` is 0, or when `cmd_addr` is 31 and the broadcast enable of bus `cmd_bus` is set; any other command changes no flag and opens no message.
- R5: Bit 0 of `stat_word` (too few words) sets the cycle after an end-of-message pulse of an open message whose `eom_cnt` is below the expected count. The expected count is 0 for transmit commands, 1 for a receive mode command with code 16..31, 0 for other mode commands, and otherwise the word count field.
- R6: Bit 1 of `stat_word` (too many words) sets the cycle after an end-of-message pulse of an open message whose `eom_cnt` exceeds the expected count.
- R7: A word count field of 0 on a receive command that is not a mode command means 32 expected words.
- R8: Bit 2 of `stat_word` (illegal broadcast) sets when an accepted command addressed to 31 needs the terminal to transmit. A command needs to transmit when `cmd_tx` is 1 and it is either not a mode command, or a mode command with code 2 or 16..31.
- R9: Any accepted command clears bits 2:0 on the next edge, except a mode command with `cmd_tx`=1 and code 2, 18 or 19, which leaves them unchanged.
- R10: When a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R11: An end-of-message pulse closes the open message; a pulse with no message open changes nothing.
- R12: Bits 3 and 4 show `bus_shut[0]` and `bus_shut[1]`, and bit 5 shows `tf_inh`, in the same cycle with no register.
- R13: Bits 6 and 7 latch `tx_tmo[0]` and `tx_tmo[1]` and hold until a `tmo_clr` strobe; a timeout input high in the clear cycle keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_we | input | 1 | Host write strobe for the address word |
| aw_wdata | input | 8 | Address word to load |
| aw_q | output | 8 | Stored address word |
| addr_err | output | 1 | Address word fails odd parity |
| cmd_vld | input | 1 | Valid command pulse |
| cmd_bus | input | 1 | Bus the command arrived on |
| cmd_addr | input | 5 | Terminal address of the command |
| cmd_tx | input | 1 | Transmit (1) / receive (0) bit |
| cmd_is_mode | input | 1 | Command is a mode command |
| cmd_field | input | 5 | Word count or mode code |
| eom_vld | input | 1 | End-of-message pulse |
| eom_cnt | input | 6 | Valid data words received in the message |
| bus_shut | input | 2 | Per-bus shutdown levels |
| tf_inh | input | 1 | Terminal flag inhibit level |
| tx_tmo | input | 2 | Per-bus transmitter timeout levels |
| tmo_clr | input | 1 | Host strobe clearing the timeout bits |
| stat_word | output | 8 | Status word |

## Verification
The hardest case to reach is a single cycle in which an end-of-message pulse for a short message and a new accepted command arrive together. The new command clears the message flags and opens a fresh message at the same edge that the old message's count comparison sets a flag. The bench gets there by opening a message that expects six words, then driving the end-of-message pulse with a count of two in the same cycle as the next command. It then closes that second message with a matching count, which shows that the flag survived and that the fresh expected count was captured. A parity-broken address word is also built on purpose, to show that only broadcasts still get through.

// File: rtl/rt_err_pkg.sv
`timescale 1ns/1ps
package rt_err_pkg;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned FIELD_W = 5;
  localparam int unsigned CNT_W   = FIELD_W + 1;
  localparam int unsigned NMSG    = 3;

  localparam logic [FIELD_W-1:0] MC_RD_STATUS  = 5'd2;
  localparam logic [FIELD_W-1:0] MC_RD_LASTCMD = 5'd18;
  localparam logic [FIELD_W-1:0] MC_RD_BIT     = 5'd19;

  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

  // odd parity over address plus its parity bit
  function automatic logic parity_good(input logic [ADDR_W:0] a);
    return ^a;
  endfunction

  // data words the terminal expects to receive for this command
  function automatic logic [CNT_W-1:0] expect_words(input logic is_mode,
                                                    input logic tx,
                                                    input logic [FIELD_W-1:0] fld);
    logic [CNT_W-1:0] n;
    if (is_mode)
      n = (!tx && fld[FIELD_W-1]) ? CNT_W'(1) : '0;
    else if (tx)
      n = '0;
    else if (fld == '0)
      n = CNT_W'(1) << FIELD_W;
    else
      n = {1'b0, fld};
    return n;
  endfunction

  // command obliges the terminal to send data back
  function automatic logic needs_tx(input logic is_mode,
                                    input logic tx,
                                    input logic [FIELD_W-1:0] fld);
    return tx && (!is_mode || fld[FIELD_W-1] || fld == MC_RD_STATUS);
  endfunction

  // status / last-command / built-in-test read-back commands
  function automatic logic is_readback(input logic is_mode,
                                       input logic tx,
                                       input logic [FIELD_W-1:0] fld);
    return is_mode && tx &&
           (fld == MC_RD_STATUS || fld == MC_RD_LASTCMD || fld == MC_RD_BIT);
  endfunction
endpackage

// File: rtl/rt_addr_word.sv
`timescale 1ns/1ps
module rt_addr_word
  import rt_err_pkg::*;
#(
  parameter int unsigned NBUS = 2,
  localparam int unsigned AW_W = ADDR_W + 1 + NBUS
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW_W-1:0]   wdata,
  output logic [AW_W-1:0]   q,
  output logic [ADDR_W-1:0] own_addr,
  output logic [NBUS-1:0]   bc_en,
  output logic              bad_par
);
  localparam logic [AW_W-1:0] AW_RST = AW_W'(1) << ADDR_W;

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= AW_RST;
    else if (we) q <= wdata;
  end

  assign own_addr = q[ADDR_W-1:0];
  assign bc_en    = q[AW_W-1:ADDR_W+1];
  assign bad_par  = !parity_good(q[ADDR_W:0]);
endmodule

// File: rtl/rt_cmd_filter.sv
`timescale 1ns/1ps
module rt_cmd_filter
  import rt_err_pkg::*;
#(
  parameter int unsigned NBUS = 2,
  localparam int unsigned BUS_W = (NBUS > 1) ? $clog2(NBUS) : 1
)(
  input  logic               cmd_vld,
  input  logic [BUS_W-1:0]   cmd_bus,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               cmd_tx,
  input  logic               cmd_is_mode,
  input  logic [FIELD_W-1:0] cmd_field,
  input  logic [ADDR_W-1:0]  own_addr,
  input  logic               bad_par,
  input  logic [NBUS-1:0]    bc_en,
  output logic               acc,
  output logic               clr_evt,
  output logic               ill_evt,
  output logic [CNT_W-1:0]   exp_cnt
);
  logic is_bc, own_hit, bc_hit;

  always_comb begin
    is_bc   = (cmd_addr == BCAST_ADDR);
    own_hit = !is_bc && !bad_par && (cmd_addr == own_addr);
    bc_hit  = is_bc && bc_en[cmd_bus];
    acc     = cmd_vld && (own_hit || bc_hit);
    clr_evt = acc && !is_readback(cmd_is_mode, cmd_tx, cmd_field);
    ill_evt = acc && is_bc && needs_tx(cmd_is_mode, cmd_tx, cmd_field);
    exp_cnt = expect_words(cmd_is_mode, cmd_tx, cmd_field);
  end
endmodule

// File: rtl/rt_wc_check.sv
`timescale 1ns/1ps
module rt_wc_check
  import rt_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [CNT_W-1:0] exp_cnt,
  input  logic             eom_vld,
  input  logic [CNT_W-1:0] eom_cnt,
  output logic             lo_evt,
  output logic             hi_evt
);
  logic [CNT_W-1:0] exp_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q  <= '0;
      open_q <= 1'b0;
    end else begin
      if (acc) begin
        exp_q  <= exp_cnt;
        open_q <= 1'b1;
      end else if (eom_vld) begin
        open_q <= 1'b0;
      end
    end
  end

  assign lo_evt = eom_vld && open_q && (eom_cnt < exp_q);
  assign hi_evt = eom_vld && open_q && (eom_cnt > exp_q);
endmodule

// File: rtl/rt_flag_bank.sv
`timescale 1ns/1ps
module rt_flag_bank #(
  parameter int unsigned N = 5
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rt_err_status.sv
`timescale 1ns/1ps
module rt_err_status
  import rt_err_pkg::*;
#(
  parameter int unsigned NBUS = 2,
  localparam int unsigned BUS_W  = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int unsigned AW_W   = ADDR_W + 1 + NBUS,
  localparam int unsigned STAT_W = NMSG + 1 + 2 * NBUS
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               aw_we,
  input  logic [AW_W-1:0]    aw_wdata,
  output logic [AW_W-1:0]    aw_q,
  output logic               addr_err,
  input  logic               cmd_vld,
  input  logic [BUS_W-1:0]   cmd_bus,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               cmd_tx,
  input  logic               cmd_is_mode,
  input  logic [FIELD_W-1:0] cmd_field,
  input  logic               eom_vld,
  input  logic [CNT_W-1:0]   eom_cnt,
  input  logic [NBUS-1:0]    bus_shut,
  input  logic               tf_inh,
  input  logic [NBUS-1:0]    tx_tmo,
  input  logic               tmo_clr,
  output logic [STAT_W-1:0]  stat_word
);
  localparam int unsigned NFLAG = NMSG + NBUS;

  logic [ADDR_W-1:0] own_addr;
  logic [NBUS-1:0]   bc_en;
  logic              acc, clr_evt, ill_evt, lo_evt, hi_evt;
  logic [CNT_W-1:0]  exp_cnt;
  logic [NFLAG-1:0]  flag_set, flag_clr, flag_q;

  rt_addr_word #(.NBUS(NBUS)) u_aw (
    .clk(clk), .rst_n(rst_n), .we(aw_we), .wdata(aw_wdata), .q(aw_q),
    .own_addr(own_addr), .bc_en(bc_en), .bad_par(addr_err)
  );

  rt_cmd_filter #(.NBUS(NBUS)) u_filt (
    .cmd_vld(cmd_vld), .cmd_bus(cmd_bus), .cmd_addr(cmd_addr),
    .cmd_tx(cmd_tx), .cmd_is_mode(cmd_is_mode), .cmd_field(cmd_field),
    .own_addr(own_addr), .bad_par(addr_err), .bc_en(bc_en),
    .acc(acc), .clr_evt(clr_evt), .ill_evt(ill_evt), .exp_cnt(exp_cnt)
  );

  rt_wc_check u_wc (
    .clk(clk), .rst_n(rst_n), .acc(acc), .exp_cnt(exp_cnt),
    .eom_vld(eom_vld), .eom_cnt(eom_cnt), .lo_evt(lo_evt), .hi_evt(hi_evt)
  );

  assign flag_set = {tx_tmo, ill_evt, hi_evt, lo_evt};
  assign flag_clr = {{NBUS{tmo_clr}}, {NMSG{clr_evt}}};

  rt_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flag_q)
  );

  assign stat_word = {flag_q[NFLAG-1:NMSG], tf_inh, bus_shut, flag_q[NMSG-1:0]};
endmodule

// File: rtl/rt_err_status_chk.sv
`timescale 1ns/1ps
module rt_err_status_chk
  import rt_err_pkg::*;
#(
  parameter int unsigned NBUS = 2,
  localparam int unsigned BUS_W  = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int unsigned STAT_W = NMSG + 1 + 2 * NBUS
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_vld,
  input logic [BUS_W-1:0]  cmd_bus,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              eom_vld,
  input logic [NBUS-1:0]   tx_tmo,
  input logic [STAT_W-1:0] stat_word,
  input logic              addr_err,
  input logic [NBUS-1:0]   bc_en,
  input logic              acc,
  input logic              clr_evt,
  input logic              ill_evt,
  input logic              lo_evt,
  input logic              hi_evt
);
  localparam int unsigned TMO_LO = NMSG + 1 + NBUS;

  // R8
  ill_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ill_evt |=> stat_word[2]);

  // R9
  readback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr_evt && !ill_evt && !lo_evt && !hi_evt)
      |=> stat_word[NMSG-1:0] == $past(stat_word[NMSG-1:0]));

  // R9
  msg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !ill_evt && !lo_evt && !hi_evt) |=> stat_word[NMSG-1:0] == '0);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_evt && clr_evt) |=> stat_word[0]);

  // R4
  bad_parity_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err && cmd_vld && cmd_addr != BCAST_ADDR) |-> !acc);

  // R4
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_addr == BCAST_ADDR && !bc_en[cmd_bus]) |-> !acc);

  // R4
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !acc && !eom_vld) |=> $stable(stat_word[NMSG-1:0]));

  // R5
  count_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_evt, hi_evt}));

  // R13
  tmo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tmo != '0) |=> (stat_word[TMO_LO +: NBUS] & $past(tx_tmo)) == $past(tx_tmo));
endmodule

bind rt_err_status rt_err_status_chk #(.NBUS(NBUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_bus(cmd_bus),
  .cmd_addr(cmd_addr), .eom_vld(eom_vld), .tx_tmo(tx_tmo),
  .stat_word(stat_word), .addr_err(addr_err), .bc_en(bc_en), .acc(acc),
  .clr_evt(clr_evt), .ill_evt(ill_evt), .lo_evt(lo_evt), .hi_evt(hi_evt)
);

// File: tb/sim_rt_err_status.sv
`timescale 1ns/1ps
module sim_rt_err_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aw_we = 1'b0;
  logic [7:0] aw_wdata = '0;
  logic [7:0] aw_q;
  logic       addr_err;
  logic       cmd_vld = 1'b0;
  logic       cmd_bus = 1'b0;
  logic [4:0] cmd_addr = '0;
  logic       cmd_tx = 1'b0;
  logic       cmd_is_mode = 1'b0;
  logic [4:0] cmd_field = '0;
  logic       eom_vld = 1'b0;
  logic [5:0] eom_cnt = '0;
  logic [1:0] bus_shut = '0;
  logic       tf_inh = 1'b0;
  logic [1:0] tx_tmo = '0;
  logic       tmo_clr = 1'b0;
  logic [7:0] stat_word;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rt_err_status u0 (
    .clk(clk), .rst_n(rst_n), .aw_we(aw_we), .aw_wdata(aw_wdata), .aw_q(aw_q),
    .addr_err(addr_err), .cmd_vld(cmd_vld), .cmd_bus(cmd_bus),
    .cmd_addr(cmd_addr), .cmd_tx(cmd_tx), .cmd_is_mode(cmd_is_mode),
    .cmd_field(cmd_field), .eom_vld(eom_vld), .eom_cnt(eom_cnt),
    .bus_shut(bus_shut), .tf_inh(tf_inh), .tx_tmo(tx_tmo), .tmo_clr(tmo_clr),
    .stat_word(stat_word)
  );

  function automatic logic [7:0] mk_aw(input logic [4:0] a, input logic b0,
                                       input logic b1, input logic spoil);
    int ones = 0;
    for (int i = 0; i < 5; i++) ones += a[i];
    return {b1, b0, ((ones % 2) == 0) ^ spoil, a};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_aw(input logic [7:0] d);
    @(negedge clk); aw_we = 1'b1; aw_wdata = d;
    @(negedge clk); aw_we = 1'b0;
  endtask

  task automatic drive_cmd(input logic bus, input logic [4:0] a, input logic tx,
                           input logic md, input logic [4:0] f);
    cmd_vld = 1'b1; cmd_bus = bus; cmd_addr = a; cmd_tx = tx;
    cmd_is_mode = md; cmd_field = f;
  endtask

  task automatic send_cmd(input logic bus, input logic [4:0] a, input logic tx,
                          input logic md, input logic [4:0] f);
    @(negedge clk); drive_cmd(bus, a, tx, md, f);
    @(negedge clk); cmd_vld = 1'b0;
  endtask

  task automatic send_eom(input logic [5:0] n);
    @(negedge clk); eom_vld = 1'b1; eom_cnt = n;
    @(negedge clk); eom_vld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 stat", 16'(stat_word), 16'h00);
    chk("R1 aw_q", 16'(aw_q), 16'h20);
    chk("R1 addr_err", 16'(addr_err), 16'h0);
  endtask

  task automatic t_addr_word;
    write_aw(mk_aw(5'd5, 1'b1, 1'b1, 1'b0));
    chk("R2 aw_q", 16'(aw_q), 16'(mk_aw(5'd5, 1'b1, 1'b1, 1'b0)));
    chk("R3 good parity", 16'(addr_err), 16'h0);
  endtask

  task automatic t_word_count;
    send_cmd(0, 5'd5, 0, 0, 5'd4); send_eom(6'd3);
    chk("R5 short msg", 16'(stat_word[2:0]), 16'h1);
    send_cmd(0, 5'd5, 0, 0, 5'd2);
    chk("R9 clear by cmd", 16'(stat_word[2:0]), 16'h0);
    send_eom(6'd2);
    chk("R5 exact count", 16'(stat_word[2:0]), 16'h0);
    send_cmd(1, 5'd5, 0, 0, 5'd2); send_eom(6'd3);
    chk("R6 long msg", 16'(stat_word[2:0]), 16'h2);
    send_cmd(0, 5'd5, 0, 0, 5'd0); send_eom(6'd32);
    chk("R7 zero means 32 full", 16'(stat_word[2:0]), 16'h0);
    send_cmd(0, 5'd5, 0, 0, 5'd0); send_eom(6'd31);
    chk("R7 zero means 32 short", 16'(stat_word[2:0]), 16'h1);
  endtask

  task automatic t_readback;
    logic [4:0] codes [3] = '{5'd2, 5'd18, 5'd19};
    foreach (codes[k]) begin
      send_cmd(0, 5'd5, 1, 1, codes[k]);
      chk($sformatf("R9 readback code %0d keeps", codes[k]), 16'(stat_word[2:0]), 16'h1);
      send_eom(6'd0);
    end
    send_cmd(0, 5'd5, 1, 1, 5'd1);
    chk("R9 other mode clears", 16'(stat_word[2:0]), 16'h0);
    send_eom(6'd0);
    send_eom(6'd5);
    chk("R11 eom without message", 16'(stat_word[2:0]), 16'h0);
  endtask

  task automatic t_broadcast;
    send_cmd(0, 5'd31, 1, 0, 5'd3);
    chk("R8 broadcast transmit", 16'(stat_word[2:0]), 16'h4);
    send_cmd(0, 5'd31, 0, 0, 5'd3);
    chk("R8 broadcast receive clears", 16'(stat_word[2:0]), 16'h0);
    send_eom(6'd3);
    send_cmd(1, 5'd31, 1, 1, 5'd1);
    chk("R8 broadcast mode code 1 legal", 16'(stat_word[2:0]), 16'h0);
    send_eom(6'd0);
  endtask

  task automatic t_bcast_gate;
    write_aw(mk_aw(5'd5, 1'b0, 1'b1, 1'b0));
    send_cmd(0, 5'd5, 0, 0, 5'd4); send_eom(6'd1);
    chk("R5 setup short", 16'(stat_word[2:0]), 16'h1);
    send_cmd(0, 5'd31, 1, 0, 5'd1);
    chk("R4 disabled bus ignored", 16'(stat_word[2:0]), 16'h1);
    send_eom(6'd9);
    chk("R4 no message opened", 16'(stat_word[2:0]), 16'h1);
    send_cmd(1, 5'd31, 1, 0, 5'd1);
    chk("R4 enabled bus accepted", 16'(stat_word[2:0]), 16'h4);
    send_eom(6'd0);
    send_cmd(0, 5'd6, 0, 0, 5'd1);
    chk("R4 foreign address ignored", 16'(stat_word[2:0]), 16'h4);
  endtask

  task automatic t_parity;
    write_aw(mk_aw(5'd5, 1'b1, 1'b1, 1'b1));
    chk("R3 bad parity", 16'(addr_err), 16'h1);
    send_cmd(0, 5'd5, 0, 0, 5'd1);
    chk("R4 own address blocked", 16'(stat_word[2:0]), 16'h4);
    send_cmd(0, 5'd31, 0, 0, 5'd1);
    chk("R4 broadcast still accepted", 16'(stat_word[2:0]), 16'h0);
    send_eom(6'd1);
    write_aw(mk_aw(5'd5, 1'b1, 1'b1, 1'b0));
    chk("R3 parity restored", 16'(addr_err), 16'h0);
  endtask

  task automatic t_same_cycle;
    send_cmd(0, 5'd5, 0, 0, 5'd6);
    @(negedge clk);
    drive_cmd(0, 5'd5, 0, 0, 5'd1);
    eom_vld = 1'b1; eom_cnt = 6'd2;
    @(negedge clk);
    cmd_vld = 1'b0; eom_vld = 1'b0;
    chk("R10 set beats clear", 16'(stat_word[2:0]), 16'h1);
    send_eom(6'd1);
    chk("R10 new expected count", 16'(stat_word[2:0]), 16'h1);
  endtask

  task automatic t_levels;
    @(negedge clk); bus_shut = 2'b01; #1;
    chk("R12 bus0 shut", 16'(stat_word[5:3]), 16'h1);
    bus_shut = 2'b10; tf_inh = 1'b1; #1;
    chk("R12 bus1 shut and inhibit", 16'(stat_word[5:3]), 16'h6);
    bus_shut = 2'b00; tf_inh = 1'b0; #1;
    chk("R12 levels drop", 16'(stat_word[5:3]), 16'h0);
  endtask

  task automatic t_timeout;
    @(negedge clk); tx_tmo = 2'b01;
    @(negedge clk); tx_tmo = 2'b00;
    chk("R13 bus0 timeout latched", 16'(stat_word[7:6]), 16'h1);
    @(negedge clk);
    chk("R13 timeout held", 16'(stat_word[7:6]), 16'h1);
    tmo_clr = 1'b1;
    @(negedge clk); tmo_clr = 1'b0;
    chk("R13 cleared by strobe", 16'(stat_word[7:6]), 16'h0);
    tmo_clr = 1'b1; tx_tmo = 2'b10;
    @(negedge clk); tmo_clr = 1'b0; tx_tmo = 2'b00;
    chk("R13 set wins over clear", 16'(stat_word[7:6]), 16'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_word();
    t_word_count();
    t_readback();
    t_broadcast();
    t_bcast_gate();
    t_parity();
    t_same_cycle();
    t_levels();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule